// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block decides, once link auto-negotiation has finished, which directions of pause-based flow control the MAC uses. It takes the local advertisement bits (pause capable, asymmetric direction), the link partner's matching ability bits, a requested mode, the auto-negotiation completion flag and the duplex of the link. From these it produces a registered 2-bit mode and two enables: one tells the transmitter that it may send pause frames, the other tells the receiver that it must honour incoming pause frames.

When auto-negotiation is enabled, a new result is taken only on a rising edge of the completion flag. The flag is first passed through a short chain of sampling registers, so a latched first reading is discarded before the rising edge is judged. When auto-negotiation is disabled, the requested mode is applied directly on every clock. A requested mode outside the legal set raises a configuration error and leaves the mode and the enables as they were. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pause_fc_resolver`

## Requirements
- R1: While `rst_n` is low and after its release, `fc_mode` is 0 and `tx_pause_en`, `rx_pause_en` and `cfg_err` are all 0 until the first update.
- R2: The mode encoding is 0 = none, 1 = receive pause only, 2 = transmit pause only, 3 = both directions. `tx_pause_en` is 1 exactly for modes 2 and 3 and `rx_pause_en` exactly for modes 1 and 3, and both change on the same clock edge as `fc_mode`.
- R3: With full duplex and both `loc_pause` and `lp_pause` set, the result is 3 when the request is 3 or 4 (default), and 1 for any other request, whatever the asymmetric bits are.
- R4: With full duplex, `loc_pause`=0, `loc_asym`=1, `lp_pause`=1 and `lp_asym`=1, the result is 2.
- R5: With full duplex, `loc_pause`=1, `loc_asym`=1, `lp_pause`=0 and `lp_asym`=1, the result is 1.
- R6: With full duplex, every combination of the four advertisement bits not covered by R3 to R5 gives 0.
- R7: When `full_duplex` is 0 at the moment of resolution, the result is 0 whatever the advertisement bits and the request are.
- R8: With `an_enable` high, a 0-to-1 change of `an_done_raw` first seen at clock edge k makes the resolved mode appear after edge k+2 (two sampling stages, then the output register). The inputs are taken at that edge. At all other times the outputs hold, whatever the advertisement, duplex or request inputs do.
- R9: With `an_enable` low, `req_mode` values 0 to 3 are applied as the mode on the next clock edge, and value 4 (default) is applied as mode 3. `cfg_err` is cleared by such an update.
- R10: With `an_enable` low, a `req_mode` of 5, 6 or 7 sets `cfg_err` on the next edge and leaves `fc_mode`, `tx_pause_en` and `rx_pause_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| an_enable | input | 1 | 1: resolve from negotiation results; 0: apply the request directly |
| an_done_raw | input | 1 | Auto-negotiation complete flag as read from the PHY status |
| full_duplex | input | 1 | 1 when the link is full duplex |
| loc_pause | input | 1 | Local pause capability advertised |
| loc_asym | input | 1 | Local asymmetric pause direction advertised |
| lp_pause | input | 1 | Link partner pause capability |
| lp_asym | input | 1 | Link partner asymmetric pause direction |
| req_mode | input | 3 | Requested mode: 0 to 3 as in R2, 4 default, 5 to 7 illegal |
| fc_mode | output | 2 | Resolved flow control mode |
| tx_pause_en | output | 1 | MAC may transmit pause frames |
| rx_pause_en | output | 1 | MAC honours received pause frames |
| cfg_err | output | 1 | Last direct request was illegal |

## Verification
A wrong resolved mode shows at `fc_mode` and at one or both enables on the edge right after the resolution, so the bench compares all three pins one sample after each update against values computed from the resolution rules. A broken sampling chain or edge detector moves or repeats updates. This shows as a mode change at the wrong edge, which the bench catches by sampling one edge before the expected update and again after fresh inputs are applied with no completion edge. A wrong error or hold path shows on the next edge as a changed mode or enable after an illegal request, or as a `cfg_err` that stays set.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  typedef enum logic [1:0] {
    FC_OFF  = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_BOTH = 2'd3
  } fc_mode_t;

  localparam int REQ_W = 3;
  localparam logic [REQ_W-1:0] REQ_DEFAULT = 3'd4;
endpackage

// File: rtl/fcr_done_edge.sv
module fcr_done_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_in,
  output logic rise
);
  logic [STAGES-1:0] samp;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) samp[0] <= 1'b0;
          else        samp[0] <= flag_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) samp[s] <= 1'b0;
          else        samp[s] <= samp[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= samp[STAGES-1];

  assign rise = samp[STAGES-1] & ~prev_q;

  // R8: a completion edge yields a single-cycle strobe
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fcr_req_norm.sv
module fcr_req_norm
  import pause_fc_pkg::*;
(
  input  logic [REQ_W-1:0] req,
  output fc_mode_t         mode,
  output logic             legal
);
  always_comb begin
    legal = 1'b1;
    mode  = FC_OFF;
    case (req)
      3'd0:        mode = FC_OFF;
      3'd1:        mode = FC_RX;
      3'd2:        mode = FC_TX;
      3'd3:        mode = FC_BOTH;
      REQ_DEFAULT: mode = FC_BOTH;
      default:     legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcr_resolve.sv
module fcr_resolve
  import pause_fc_pkg::*;
(
  input  logic     loc_pause,
  input  logic     loc_asym,
  input  logic     lp_pause,
  input  logic     lp_asym,
  input  logic     full_duplex,
  input  logic     want_full,
  output fc_mode_t mode
);
  always_comb begin
    if (!full_duplex)
      mode = FC_OFF;
    else if (loc_pause && lp_pause)
      mode = want_full ? FC_BOTH : FC_RX;
    else if (!loc_pause && loc_asym && lp_pause && lp_asym)
      mode = FC_TX;
    else if (loc_pause && loc_asym && !lp_pause && lp_asym)
      mode = FC_RX;
    else
      mode = FC_OFF;
  end
endmodule

// File: rtl/fcr_mode_reg.sv
module fcr_mode_reg
  import pause_fc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  logic     legal,
  input  fc_mode_t new_mode,
  output fc_mode_t mode_q,
  output logic     tx_en,
  output logic     rx_en,
  output logic     err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FC_OFF;
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd) begin
      err_q <= ~legal;
      if (legal) begin
        mode_q <= new_mode;
        tx_en  <= (new_mode == FC_TX) || (new_mode == FC_BOTH);
        rx_en  <= (new_mode == FC_RX) || (new_mode == FC_BOTH);
      end
    end
  end

  // R10: an illegal update leaves the enables where they were
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !legal) |=> ($stable(tx_en) && $stable(rx_en) && err_q));
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import pause_fc_pkg::*;
#(
  parameter int READ_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             an_enable,
  input  logic             an_done_raw,
  input  logic             full_duplex,
  input  logic             loc_pause,
  input  logic             loc_asym,
  input  logic             lp_pause,
  input  logic             lp_asym,
  input  logic [REQ_W-1:0] req_mode,
  output logic [1:0]       fc_mode,
  output logic             tx_pause_en,
  output logic             rx_pause_en,
  output logic             cfg_err
);
  logic     done_rise;
  fc_mode_t req_norm;
  logic     req_legal;
  fc_mode_t neg_mode;
  fc_mode_t sel_mode;
  fc_mode_t mode_q;
  logic     upd;
  logic     upd_legal;

  fcr_done_edge #(.STAGES(READ_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .flag_in(an_done_raw), .rise(done_rise)
  );

  fcr_req_norm u_norm (
    .req(req_mode), .mode(req_norm), .legal(req_legal)
  );

  fcr_resolve u_res (
    .loc_pause(loc_pause), .loc_asym(loc_asym),
    .lp_pause(lp_pause), .lp_asym(lp_asym),
    .full_duplex(full_duplex),
    .want_full(req_legal && (req_norm == FC_BOTH)),
    .mode(neg_mode)
  );

  always_comb begin
    if (an_enable) begin
      upd       = done_rise;
      upd_legal = 1'b1;
      sel_mode  = neg_mode;
    end else begin
      upd       = 1'b1;
      upd_legal = req_legal;
      sel_mode  = req_norm;
    end
  end

  fcr_mode_reg u_reg (
    .clk(clk), .rst_n(rst_n), .upd(upd), .legal(upd_legal),
    .new_mode(sel_mode), .mode_q(mode_q),
    .tx_en(tx_pause_en), .rx_en(rx_pause_en), .err_q(cfg_err)
  );

  assign fc_mode = mode_q;

  // R8: without a completion edge, negotiation mode holds the outputs
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && !done_rise) |=> $stable(fc_mode));

  // R7: half duplex at resolution forces flow control off
  p_half_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && done_rise && !full_duplex) |=> (fc_mode == 2'd0));

  // R3: symmetric result downgraded unless full is requested
  p_sym_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && done_rise && full_duplex && loc_pause && lp_pause &&
     req_mode != 3'd3 && req_mode != 3'd4) |=> (fc_mode == 2'd1));

  // R9: default request maps to full in direct mode
  p_default_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!an_enable && req_mode == 3'd4) |=> (fc_mode == 2'd3 && !cfg_err));
endmodule

// File: tb/sim_pause_fc_resolver.sv
module sim_pause_fc_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic an_enable = 1'b1, an_done_raw = 1'b0, full_duplex = 1'b1;
  logic loc_pause = 1'b0, loc_asym = 1'b0, lp_pause = 1'b0, lp_asym = 1'b0;
  logic [2:0] req_mode = 3'd3;
  logic [1:0] fc_mode;
  logic tx_pause_en, rx_pause_en, cfg_err;

  int total = 0;
  int bad = 0;
  logic [1:0] cur = 2'd0;

  always #4 clk = ~clk;

  pause_fc_resolver u0 (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_done_raw(an_done_raw),
    .full_duplex(full_duplex), .loc_pause(loc_pause), .loc_asym(loc_asym),
    .lp_pause(lp_pause), .lp_asym(lp_asym), .req_mode(req_mode),
    .fc_mode(fc_mode), .tx_pause_en(tx_pause_en), .rx_pause_en(rx_pause_en),
    .cfg_err(cfg_err)
  );

  function automatic logic [1:0] exp_res(logic lp, logic la, logic pp, logic pa,
                                         logic [2:0] rq, logic fd);
    if (!fd) return 2'd0;
    if (lp && pp) return (rq == 3'd3 || rq == 3'd4) ? 2'd3 : 2'd1;
    if (!lp && la && pp && pa) return 2'd2;
    if (lp && la && !pp && pa) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [1:0] m, input logic e);
    chk({tag, " mode"}, fc_mode, m);
    chk("R2 tx enable", tx_pause_en, m[1]);
    chk("R2 rx enable", rx_pause_en, m == 2'd1 || m == 2'd3);
    chk({tag, " err"}, cfg_err, e);
  endtask

  task automatic run_an(input logic lp, input logic la, input logic pp, input logic pa,
                        input logic [2:0] rq, input logic fd, input string tag);
    logic [1:0] e;
    @(negedge clk);
    an_enable = 1'b1; an_done_raw = 1'b0;
    loc_pause = ~lp; loc_asym = ~la; lp_pause = ~pp; lp_asym = ~pa;
    req_mode = rq ^ 3'd1; full_duplex = ~fd;
    repeat (4) @(negedge clk);
    chk_out("R8 hold without edge", cur, cfg_err);
    loc_pause = lp; loc_asym = la; lp_pause = pp; lp_asym = pa;
    req_mode = rq; full_duplex = fd; an_done_raw = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no early update", fc_mode, cur);
    @(negedge clk);
    e = exp_res(lp, la, pp, pa, rq, fd);
    chk_out(tag, e, 1'b0);
    cur = e;
    repeat (2) @(negedge clk);
    chk("R8 single update", fc_mode, cur);
  endtask

  task automatic run_direct(input logic [2:0] rq);
    logic [1:0] e;
    @(negedge clk);
    an_enable = 1'b0; req_mode = rq;
    @(negedge clk);
    if (rq <= 3'd4) begin
      e = (rq == 3'd4) ? 2'd3 : rq[1:0];
      chk_out("R9 direct", e, 1'b0);
      cur = e;
    end else begin
      chk_out("R10 illegal", cur, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 2'd0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_out("R1 after reset", 2'd0, 1'b0);

    // directed resolution corners
    run_an(1, 0, 1, 0, 3'd3, 1, "R3 sym full");
    run_an(1, 1, 1, 1, 3'd1, 1, "R3 sym rx-only request");
    run_an(1, 0, 1, 1, 3'd4, 1, "R3 sym default");
    run_an(1, 1, 1, 0, 3'd2, 1, "R3 sym tx request");
    run_an(0, 1, 1, 1, 3'd3, 1, "R4 tx only");
    run_an(1, 1, 0, 1, 3'd3, 1, "R5 rx only");
    run_an(0, 1, 1, 0, 3'd3, 1, "R6 none");
    run_an(1, 0, 0, 1, 3'd3, 1, "R6 none b");
    run_an(0, 0, 1, 1, 3'd3, 1, "R6 none c");
    run_an(1, 1, 1, 1, 3'd3, 0, "R7 half duplex");
    run_an(0, 1, 1, 1, 3'd3, 0, "R7 half duplex tx");

    // direct path corners
    run_direct(3'd2);
    run_direct(3'd5);
    run_direct(3'd7);
    run_direct(3'd4);
    run_direct(3'd6);
    run_direct(3'd1);
    run_direct(3'd0);
    run_direct(3'd3);

    // constrained random mix
    for (int i = 0; i < 200; i++) begin
      logic [7:0] r;
      r = 8'($urandom());
      if (r[7:6] == 2'b00)
        run_direct(r[2:0]);
      else
        run_an(r[0], r[1], r[2], r[3], 3'($urandom_range(0, 7)),
               ($urandom_range(0, 3) != 0), "R3-R7 random resolve");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule